// File: doc/BRIEF.md
# ADC scan sequencer with triggers

This block is the digital controller that sits in front of a successive-approximation converter core. Once enabled, it waits for an edge on one of four start lines. It then steps through the channels that have their enable bit set, lowest index first. For each one it tells the core which channel to sample and at what resolution, and it holds the conversion open for a number of clock cycles that depends on that resolution. At the end of the window it takes the core's raw value, left-aligns it and stores it in that channel's result register.

A single-shot scan stops after the highest enabled channel, drops busy and raises done. A continuous scan goes straight back to the lowest enabled channel. Each result is compared in hardware with a per-channel threshold, using a per-channel greater-than or less-than choice. A status bit is raised only when that comparison holds. Another status bit is raised at every end of scan. Status bits are sticky, are cleared by writing ones, and drive a single interrupt line through an enable mask.

All configuration arrives as register-style level inputs, so the block can sit directly behind a register file. Clock generation and the analog part are outside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, done, conv_start, irq, every irq_status bit and every result field are 0.
- R2: trig_sel is the index of the trig_in line that starts a scan. trig_rise = 1 starts on a 0-to-1 change of that line and trig_rise = 0 starts on a 1-to-0 change. The opposite edge, and any change on a line that is not selected, start nothing.
- R3: Each conversion keeps busy high for exactly r+1 clock cycles, where r is the channel's effective resolution. conv_start is high only in the first of those cycles.
- R4: A scan converts only the channels whose ch_en bit is 1, in ascending index order, and conv_ch shows the channel being converted. The result registers of disabled channels keep their values.
- R5: The resolution of channel i is the 4-bit field ch_res[4i+3:4i]. Codes below 2 act as 2 and codes above 10 act as 10, and conv_res shows the effective value.
- R6: At the end of a conversion with resolution r, result[10i+9:10i] is loaded with conv_data[r-1:0] shifted left by 10-r. The low 10-r bits are zero and the conv_data bits above r-1 are ignored.
- R7: In single-shot mode (cont = 0), busy falls after the last enabled channel and done rises in the same cycle. done returns to 0 when the next scan starts. A start edge with no channel enabled sets done without any busy cycle.
- R8: In continuous mode (cont = 1), the sequencer returns to the lowest enabled channel with no new start edge, and busy stays high.
- R9: When a result is stored, irq_status[i] is set if ch_gt[i] = 1 and the result is greater than ch_thr[10i+9:10i]. It is also set if ch_gt[i] = 0 and the result is less than that threshold. Otherwise irq_status[i] does not change.
- R10: irq_status[NCH] is set at every end of scan, including an empty scan. irq is the OR of irq_status bits whose matching irq_en bit is 1.
- R11: A 1 in irq_clr clears the matching irq_status bit on the next clock edge. A status event in that same cycle keeps the bit at 1, and status bits never fall without a clear.
- R12: A start edge that arrives while busy is high has no effect: the scan length is unchanged and no new scan follows.
- R13: While en is 0, the sequencer is idle one cycle later and ignores start edges. Dropping en in the middle of a scan aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the conversion timebase |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Sequencer enable |
| cont | input | 1 | 1 = continuous scan, 0 = single-shot |
| trig_sel | input | 2 | Index of the start line in use |
| trig_rise | input | 1 | 1 = rising edge starts, 0 = falling |
| trig_in | input | 4 | Start lines (external, timer, PWM sync, preceding converter) |
| ch_en | input | 4 | Per-channel enable |
| ch_res | input | 16 | Per-channel resolution codes, 4 bits each |
| ch_thr | input | 40 | Per-channel thresholds, 10 bits each |
| ch_gt | input | 4 | Per-channel compare sense, 1 = greater-than |
| irq_en | input | 5 | Interrupt enable per status bit |
| irq_clr | input | 5 | Write-one-to-clear for status bits |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_ch | output | 2 | Channel being converted |
| conv_res | output | 4 | Effective resolution of the current conversion |
| conv_data | input | 10 | Raw value from the core, right-aligned |
| busy | output | 1 | A scan is running |
| done | output | 1 | Last single-shot scan has finished |
| result | output | 40 | Per-channel left-aligned results, 10 bits each |
| irq_status | output | 5 | Sticky status: compare hits in bits 3..0, end of scan in bit 4 |
| irq | output | 1 | Interrupt request |

## Verification
A table of six configurations exercises the main scan path. Between them they use every start line, both edge senses, dense and sparse channel masks, an empty mask, and resolution codes below, inside and above the legal range. Each configuration tells apart the conversion order, the conversion length (which shows up as the busy duration per resolution), the alignment and masking of the stored values, and which comparisons raise status. Because the fixed core values fall on both sides of the thresholds, a swapped comparison sense or a wrong shift shows up as a mismatch. Directed cases then cover opposite-edge and wrong-line rejection, edges while disabled, the continuous wrap, abort, and the clear-versus-event race. For the race the clear is held high while end-of-scan events recur, and the share of cycles with the status bit high is counted.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   localparam int RES_MIN = 2;
   typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seq_state_t;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int NSRC = 4,
   parameter int SW   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lines,
   input  logic [SW-1:0]   sel,
   input  logic            rising,
   output logic            fire
);
   logic [NSRC-1:0] prev_q;
   logic            now_v;
   logic            old_v;

   // all lines are remembered so that a change of sel never fakes an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   assign now_v = lines[sel];
   assign old_v = prev_q[sel];
   assign fire  = rising ? (now_v & ~old_v) : (~now_v & old_v);
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH = 4,
   parameter int CW  = 2
) (
   input  logic [NCH-1:0] mask,
   input  logic [CW-1:0]  after,
   input  logic           from_start,
   output logic           found,
   output logic [CW-1:0]  ch
);
   // downward walk so the lowest qualifying index is the one left standing
   always_comb begin
      found = 1'b0;
      ch    = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask[i] && (from_start || (i > int'(after)))) begin
            found = 1'b1;
            ch    = CW'(i);
         end
      end
   end
endmodule

// File: rtl/adc_result_align.sv
module adc_result_align #(
   parameter int RW  = 10,
   parameter int RCW = 4
) (
   input  logic [RW-1:0]  raw,
   input  logic [RCW-1:0] res,
   input  logic [RW-1:0]  thr,
   input  logic           gt,
   output logic [RW-1:0]  aligned,
   output logic           hit
);
   logic [RW-1:0] keep;
   logic [RW-1:0] masked;

   assign keep    = ~({RW{1'b1}} << res);
   assign masked  = raw & keep;
   assign aligned = masked << (RW - int'(res));
   assign hit     = gt ? (aligned > thr) : (aligned < thr);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int  NCH  = 4,
   parameter int  NSRC = 4,
   parameter int  RW   = 10,
   localparam int CW   = $clog2(NCH),
   localparam int SW   = $clog2(NSRC),
   localparam int RCW  = $clog2(RW + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             cont,
   input  logic [SW-1:0]    trig_sel,
   input  logic             trig_rise,
   input  logic [NSRC-1:0]  trig_in,
   input  logic [NCH-1:0]   ch_en,
   input  logic [NCH*RCW-1:0] ch_res,
   input  logic [NCH*RW-1:0]  ch_thr,
   input  logic [NCH-1:0]   ch_gt,
   input  logic [NCH:0]     irq_en,
   input  logic [NCH:0]     irq_clr,
   output logic             conv_start,
   output logic [CW-1:0]    conv_ch,
   output logic [RCW-1:0]   conv_res,
   input  logic [RW-1:0]    conv_data,
   output logic             busy,
   output logic             done,
   output logic [NCH*RW-1:0] result,
   output logic [NCH:0]     irq_status,
   output logic             irq
);
   initial begin
      if (NCH < 2 || (1 << CW) != NCH) $fatal(1, "NCH must be a power of two, at least 2");
      if (NSRC < 2 || (1 << SW) != NSRC) $fatal(1, "NSRC must be a power of two, at least 2");
      if (RW < RES_MIN || RW > 15) $fatal(1, "RW out of supported range");
   end

   seq_state_t     state_q;
   logic [CW-1:0]  ch_q;
   logic [RCW-1:0] cnt_q;
   logic           start_q;
   logic           done_q;
   logic [NCH:0]   stat_q;
   logic [NCH:0]   ev;
   logic [RW-1:0]  res_q  [NCH];
   logic [RCW-1:0] eff_res[NCH];
   logic [RW-1:0]  thr_a  [NCH];

   logic           fire;
   logic           first_found, next_found;
   logic [CW-1:0]  first_ch, next_ch;
   logic [RCW-1:0] cur_res;
   logic [RW-1:0]  aligned;
   logic           hit;
   logic           conv_last;
   logic           scan_end;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_cfg
         logic [RCW-1:0] code;
         assign code       = ch_res[i*RCW +: RCW];
         assign eff_res[i] = (code < RES_MIN) ? RCW'(RES_MIN) :
                             (code > RW)      ? RCW'(RW) : code;
         assign thr_a[i]   = ch_thr[i*RW +: RW];
      end
   endgenerate

   adc_trig_edge #(.NSRC(NSRC), .SW(SW)) u_trig (
      .clk(clk), .rst_n(rst_n), .lines(trig_in), .sel(trig_sel),
      .rising(trig_rise), .fire(fire)
   );

   adc_chan_pick #(.NCH(NCH), .CW(CW)) u_first (
      .mask(ch_en), .after('0), .from_start(1'b1),
      .found(first_found), .ch(first_ch)
   );

   adc_chan_pick #(.NCH(NCH), .CW(CW)) u_next (
      .mask(ch_en), .after(ch_q), .from_start(1'b0),
      .found(next_found), .ch(next_ch)
   );

   assign cur_res = eff_res[ch_q];

   adc_result_align #(.RW(RW), .RCW(RCW)) u_align (
      .raw(conv_data), .res(cur_res), .thr(thr_a[ch_q]), .gt(ch_gt[ch_q]),
      .aligned(aligned), .hit(hit)
   );

   assign conv_last = (state_q == SEQ_CONV) && (cnt_q == '0);
   assign scan_end  = en && ((conv_last && !next_found) ||
                             ((state_q == SEQ_IDLE) && fire && !first_found));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ch_q    <= '0;
         cnt_q   <= '0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!en) begin
            state_q <= SEQ_IDLE;
         end else begin
            unique case (state_q)
               SEQ_IDLE: begin
                  if (fire) begin
                     if (first_found) begin
                        done_q  <= 1'b0;
                        state_q <= SEQ_CONV;
                        ch_q    <= first_ch;
                        cnt_q   <= eff_res[first_ch];
                        start_q <= 1'b1;
                     end else begin
                        done_q  <= 1'b1;
                     end
                  end
               end
               SEQ_CONV: begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                  end else if (next_found) begin
                     ch_q    <= next_ch;
                     cnt_q   <= eff_res[next_ch];
                     start_q <= 1'b1;
                  end else if (cont && first_found) begin
                     ch_q    <= first_ch;
                     cnt_q   <= eff_res[first_ch];
                     start_q <= 1'b1;
                  end else begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end
               end
               default: state_q <= SEQ_IDLE;
            endcase
         end
      end
   end

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_slot
         assign ev[i] = en && conv_last && hit && (ch_q == CW'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   res_q[i] <= '0;
            else if (en && conv_last && (ch_q == CW'(i))) res_q[i] <= aligned;
         end
         assign result[i*RW +: RW] = res_q[i];
      end
   endgenerate
   assign ev[NCH] = scan_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~irq_clr) | ev;
   end

   assign conv_start = start_q;
   assign conv_ch    = ch_q;
   assign conv_res   = cur_res;
   assign busy       = (state_q == SEQ_CONV);
   assign done       = done_q;
   assign irq_status = stat_q;
   assign irq        = |(stat_q & irq_en);
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
   import adc_scan_pkg::*;
#(
   parameter int RW  = 10,
   parameter int RCW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           en,
   input logic           busy,
   input logic           done,
   input logic           conv_start,
   input logic [RCW-1:0] conv_res,
   input logic           end_clr,
   input logic           end_stat
);
   AST_START_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);                                                   // R3
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);                                            // R3
   AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (conv_res >= RES_MIN && conv_res <= RW));                // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                        // R7
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(end_stat) |-> $past(end_clr));                                    // R11
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);                                                         // R13
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.RW(RW), .RCW(RCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .busy(busy), .done(done),
   .conv_start(conv_start), .conv_res(conv_res),
   .end_clr(irq_clr[NCH]), .end_stat(irq_status[NCH])
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en, cont, trig_rise;
   logic [1:0]  trig_sel;
   logic [3:0]  trig_in, ch_en, ch_gt;
   logic [15:0] ch_res;
   logic [39:0] ch_thr;
   logic [4:0]  irq_en, irq_clr;
   logic        conv_start, busy, done, irq;
   logic [1:0]  conv_ch;
   logic [3:0]  conv_res;
   logic [9:0]  conv_data;
   logic [39:0] result;
   logic [4:0]  irq_status;

   int checks = 0;
   int fails  = 0;
   logic [9:0] mres [4];

   // {mask, select, rising, res3, res2, res1, res0}
   localparam logic [22:0] VEC [6] = '{
      {4'b1111, 2'd0, 1'b1, 16'hAAAA},
      {4'b0101, 2'd1, 1'b0, 16'hA4A8},
      {4'b1010, 2'd2, 1'b1, 16'h6A2A},
      {4'b1001, 2'd3, 1'b0, 16'hFAA0},
      {4'b0010, 2'd0, 1'b0, 16'hAA5A},
      {4'b0000, 2'd1, 1'b1, 16'hAAAA}
   };

   adc_scan_seq uut (
      .clk(clk), .rst_n(rst_n), .en(en), .cont(cont), .trig_sel(trig_sel),
      .trig_rise(trig_rise), .trig_in(trig_in), .ch_en(ch_en), .ch_res(ch_res),
      .ch_thr(ch_thr), .ch_gt(ch_gt), .irq_en(irq_en), .irq_clr(irq_clr),
      .conv_start(conv_start), .conv_ch(conv_ch), .conv_res(conv_res),
      .conv_data(conv_data), .busy(busy), .done(done), .result(result),
      .irq_status(irq_status), .irq(irq)
   );

   function automatic logic [9:0] sval(input int ch);
      case (ch)
         0: return 10'h3A5;
         1: return 10'h155;
         2: return 10'h2AA;
         default: return 10'h0F3;
      endcase
   endfunction

   // behavioural core: full-width value, upper bits beyond the resolution are junk
   assign conv_data = sval(int'(conv_ch));

   function automatic int effr(input logic [3:0] c);
      if (c < 4'd2)  return 2;
      if (c > 4'd10) return 10;
      return int'(c);
   endfunction

   function automatic logic [9:0] model_res(input int ch, input int r);
      logic [9:0] m;
      m = 10'((1 << r) - 1);
      return 10'((sval(ch) & m) << (10 - r));
   endfunction

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input logic [22:0] v);
      logic [3:0]  m;
      logic [1:0]  s;
      logic        e;
      logic [15:0] r;
      int          exp_len, exp_n, got_n, n;
      logic [31:0] exp_seq, got_seq;
      logic [3:0]  exp_hit;
      m = v[22:19]; s = v[18:17]; e = v[16]; r = v[15:0];
      @(negedge clk);
      ch_en = m; trig_sel = s; trig_rise = e; ch_res = r; cont = 1'b0; en = 1'b1;
      irq_en = '1; trig_in = e ? 4'b0000 : 4'b1111; irq_clr = '1;
      @(negedge clk);
      irq_clr = '0;
      repeat (2) @(negedge clk);
      exp_len = 0; exp_n = 0; exp_seq = '0; exp_hit = '0;
      for (int ch = 0; ch < 4; ch++) begin
         if (m[ch]) begin
            int rr;
            rr = effr(r[ch*4 +: 4]);
            exp_len += rr + 1;
            exp_seq = {exp_seq[29:0], 2'(ch)};
            exp_n++;
            mres[ch] = model_res(ch, rr);
            if (ch_gt[ch] ? (mres[ch] > ch_thr[ch*10 +: 10]) : (mres[ch] < ch_thr[ch*10 +: 10]))
               exp_hit[ch] = 1'b1;
         end
      end
      trig_in[s] = e;
      @(negedge clk);
      n = 0; got_n = 0; got_seq = '0;
      while (busy && n < 200) begin
         if (n == 0) check("R7 done cleared at scan start", done, 0);
         if (conv_start) begin
            got_seq = {got_seq[29:0], conv_ch};
            got_n++;
         end
         if (n == 3) trig_in[s] = ~e;
         if (n == 4) trig_in[s] = e;   // edge while busy
         n++;
         @(negedge clk);
      end
      check("R3 busy length", n, exp_len);
      check("R4 conversion count", got_n, exp_n);
      check("R4 conversion order", got_seq, exp_seq);
      check("R7 done after scan", done, 1);
      for (int ch = 0; ch < 4; ch++)
         check("R5 R6 result", result[ch*10 +: 10], mres[ch]);
      check("R9 compare status", irq_status[3:0], exp_hit);
      check("R10 end-of-scan status", irq_status[4], 1);
      check("R10 irq raised", irq, 1);
      repeat (5) @(negedge clk);
      check("R12 edge while busy ignored", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n1, starts;
      logic [3:0] low_before;
      rst_n = 1'b0; en = 1'b0; cont = 1'b0; trig_sel = '0; trig_rise = 1'b1;
      trig_in = '0; ch_en = '0; ch_res = 16'hAAAA; irq_en = '0; irq_clr = '0;
      ch_thr = {10'h080, 10'h200, 10'h100, 10'h200};
      ch_gt  = 4'b0101;
      for (int i = 0; i < 4; i++) mres[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 conv_start", conv_start, 0);
      check("R1 status", irq_status, 0);
      check("R1 result", result, 0);
      check("R1 irq", irq, 0);

      for (int k = 0; k < 6; k++) run_vec(VEC[k]);

      // R10 interrupt masking, status holds only bit 4 after the empty scan
      irq_en = 5'b00000; @(negedge clk);
      check("R10 irq masked", irq, 0);
      irq_en = 5'b10000; @(negedge clk);
      check("R10 irq enabled bit", irq, 1);
      irq_en = 5'b00001; @(negedge clk);
      check("R10 irq other bit", irq, 0);

      // R2 wrong line and opposite edge start nothing
      ch_en = 4'b0001; ch_res = 16'hAAAA; trig_sel = 2'd2; trig_rise = 1'b0;
      trig_in = 4'b0000; cont = 1'b0; en = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 4'b0110;
      repeat (3) @(negedge clk);
      check("R2 opposite edge or other line ignored", busy, 0);
      trig_in[2] = 1'b0;
      @(negedge clk);
      check("R2 selected falling edge starts", busy, 1);
      n1 = 0;
      while (busy && n1 < 50) begin n1++; @(negedge clk); end

      // R13 edges while disabled
      en = 1'b0; trig_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      trig_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      check("R13 disabled ignores edge", busy, 0);

      // R8 continuous wrap, one channel at code 2: 3-cycle conversions
      en = 1'b1; cont = 1'b1; ch_res = 16'hAAA2; trig_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      trig_in[2] = 1'b0;
      @(negedge clk);
      n1 = 0; starts = 0;
      for (int i = 0; i < 21; i++) begin
         if (busy) n1++;
         if (conv_start) starts++;
         @(negedge clk);
      end
      check("R8 busy held in continuous", n1, 21);
      check("R8 R3 restarts without trigger", starts, 7);

      // R11 clear held while end-of-scan events recur
      irq_clr = 5'b10000;
      n1 = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (irq_status[4]) n1++;
      end
      check("R11 event wins over clear", n1, 10);
      irq_clr = '0;
      repeat (4) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check("R13 abort within one cycle", busy, 0);
      check("R11 status sticky", irq_status[4], 1);
      low_before = irq_status[3:0];
      irq_clr = 5'b10000;
      @(negedge clk);
      irq_clr = '0;
      check("R11 clear removes bit", irq_status[4], 0);
      check("R11 clear leaves other bits", irq_status[3:0], low_before);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule